// File: doc/BRIEF.md
# Load/Store Ordering Buffer

This block keeps track of memory micro-operations that are in flight between issue and retirement. Loads and stores go into two separate circular queues in program order. Each cycle the block chooses at most one entry to offer to the cache port. Stores leave strictly in program order, and only after every older load has gone out. Loads may overtake one another, but never an older store. Ordering is enforced without comparing addresses. When a load is allocated it records the store-queue allocation pointer, which is the tag of the next store to arrive. That value is its color. A load becomes eligible once the in-order store dispatch pointer has caught up with its color.

A load that missed in the cache can be replayed. The replayed entry becomes eligible again at once, without regard to its color, and it competes only on age, so it never holds back other eligible work. Completions mark entries as finished. Retirement frees the head of either queue, and only if that head has completed. The cache port may apply back-pressure. While it does, the offered operation stays put.

Top module: `memord_buf`

## Requirements
- R1: After reset nothing is offered for dispatch, both queues are empty (alloc_ready is high for either operation type) and alloc_idx reads 0.
- R2: An allocation is accepted when alloc_valid and alloc_ready are both high. Each queue hands out slots circularly from 0, and alloc_idx shows the slot in use. alloc_ready is low only when the queue of the requested type is full (16 loads or 12 stores). The other queue is not affected.
- R3: Stores are dispatched in allocation order, and a store is dispatched only after every load allocated before it has been dispatched.
- R4: A load is dispatched only after every store allocated before it has been dispatched.
- R5: Among the eligible loads the oldest one, by circular position from the load-queue head, is offered first. A younger load does not wait for an older load to complete.
- R6: When the next in-order store and a load are both eligible, the store is offered.
- R7: While disp_valid is high and disp_ready is low, the offered operation (disp_is_store, disp_idx) is held and no state advances, unless an allocation or a replay arrives.
- R8: A replay request (rpl_valid, load slot rpl_idx) on a load that was dispatched but has not completed makes it eligible again, regardless of later stores. A replay on any other slot has no effect.
- R9: ret_load or ret_store frees the head of its queue only if that head has completed (cmp_valid with cmp_is_store=1 for stores, 0 for loads, and slot cmp_idx). Otherwise the request is ignored.
- R10: The store tags carry a wrap bit, so a queue that has been filled and completely drained reads as empty and keeps ordering loads against stores correctly after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | Target queue has room |
| alloc_idx | output | 4 | Slot given to the allocated operation |
| disp_valid | output | 1 | An operation is offered to the cache |
| disp_is_store | output | 1 | Offered operation is a store |
| disp_idx | output | 4 | Queue slot of the offered operation |
| disp_ready | input | 1 | Cache port accepts the offer this cycle |
| cmp_valid | input | 1 | Completion report |
| cmp_is_store | input | 1 | Completion targets the store queue |
| cmp_idx | input | 4 | Completed slot |
| rpl_valid | input | 1 | Replay request for a load |
| rpl_idx | input | 4 | Load slot to replay |
| ret_load | input | 1 | Retire the load-queue head |
| ret_store | input | 1 | Retire the store-queue head |

## Verification
A stale color or a store dispatch pointer that has slipped shows up at the dispatch port within a cycle or two. Either a load appears ahead of the store it should follow, or both queues stall with disp_valid low while work is pending. A fault in the oldest-first selection shows as a swapped slot order. This is most visible right after the load head wraps, when the oldest entry has the highest index. Pointer faults, including a lost wrap bit, show as a wrong alloc_idx or a wrong alloc_ready value right at the boundary where a queue fills or drains.

// File: rtl/memord_pkg.sv
// Shared types for the load/store ordering buffer.
package memord_pkg;
    // Life cycle of one load-queue slot.
    typedef enum logic [1:0] {
        LS_FREE = 2'd0,
        LS_WAIT = 2'd1,
        LS_SENT = 2'd2,
        LS_DONE = 2'd3
    } ld_state_e;
endpackage

// File: rtl/memord_sq.sv
// Store queue: circular buffer of stores that dispatch strictly in order.
// Pointers count 0..2*DEPTH-1, so the upper half acts as the wrap bit.
// Assumes: the parent gates alloc_en with !full and grant with cand.
module memord_sq #(
    parameter int DEPTH = 12,
    localparam int PW = $clog2(2 * DEPTH),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    output logic          full,
    output logic [PW-1:0] tail_ptr,
    output logic [IW-1:0] tail_idx,
    output logic [PW-1:0] disp_ptr,
    output logic [IW-1:0] disp_idx,
    output logic          cand,
    input  logic          grant,
    input  logic          cmp_en,
    input  logic [IW-1:0] cmp_idx,
    input  logic          ret_en
);
    logic [PW-1:0]    head_q, tail_q, disp_q;
    logic [DEPTH-1:0] done_q;
    logic             head_ok;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        if (p == PW'(2 * DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    function automatic logic [IW-1:0] ptr_idx(input logic [PW-1:0] p);
        if (p >= PW'(DEPTH)) return IW'(p - PW'(DEPTH));
        return IW'(p);
    endfunction

    function automatic logic [PW-1:0] ptr_dist(input logic [PW-1:0] a, input logic [PW-1:0] b);
        logic [PW:0] t;
        t = {1'b0, a} + (PW+1)'(2 * DEPTH) - {1'b0, b};
        if (t >= (PW+1)'(2 * DEPTH)) t = t - (PW+1)'(2 * DEPTH);
        return t[PW-1:0];
    endfunction

    // Status derived from the pointers.
    always_comb begin
        full     = (ptr_dist(tail_q, head_q) == PW'(DEPTH));
        cand     = (disp_q != tail_q);
        head_ok  = (head_q != disp_q) && done_q[ptr_idx(head_q)];
        tail_ptr = tail_q;
        tail_idx = ptr_idx(tail_q);
        disp_ptr = disp_q;
        disp_idx = ptr_idx(disp_q);
    end

    // Pointer and completion-flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            disp_q <= '0;
            done_q <= '0;
        end else begin
            if (alloc_en) begin
                done_q[ptr_idx(tail_q)] <= 1'b0;
                tail_q <= ptr_inc(tail_q);
            end
            if (grant) disp_q <= ptr_inc(disp_q);
            if (cmp_en) done_q[cmp_idx] <= 1'b1;
            if (ret_en && head_ok) head_q <= ptr_inc(head_q);
        end
    end

    // R2: the parent never pushes into a full store queue.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_en);
    // R10: the in-order dispatch pointer stays between head and tail across wraps.
    p_disp_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_dist(disp_q, head_q) <= ptr_dist(tail_q, head_q));
endmodule

// File: rtl/memord_lq.sv
// Load queue: each slot keeps its color (the store pointer at allocation)
// and a replay flag. It picks the oldest eligible load and reports whether
// a pending load still holds back the next in-order store.
// Assumes: the parent gates alloc_en with !full and grant with cand.
module memord_lq
    import memord_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SPW   = 5,
    localparam int PW = $clog2(2 * DEPTH),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_en,
    input  logic [SPW-1:0] alloc_color,
    output logic           full,
    output logic [IW-1:0]  tail_idx,
    input  logic [SPW-1:0] store_ptr,
    output logic           st_block,
    output logic           cand,
    output logic [IW-1:0]  cand_idx,
    input  logic           grant,
    input  logic           cmp_en,
    input  logic [IW-1:0]  cmp_idx,
    input  logic           rpl_en,
    input  logic [IW-1:0]  rpl_idx,
    input  logic           ret_en
);
    ld_state_e        state_q [DEPTH];
    logic [SPW-1:0]   color_q [DEPTH];
    logic [DEPTH-1:0] rpl_q;
    logic [DEPTH-1:0] elig, blk;
    logic [PW-1:0]    head_q, tail_q;
    logic [IW-1:0]    head_idx;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        if (p == PW'(2 * DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    function automatic logic [IW-1:0] ptr_idx(input logic [PW-1:0] p);
        if (p >= PW'(DEPTH)) return IW'(p - PW'(DEPTH));
        return IW'(p);
    endfunction

    function automatic logic [PW-1:0] ptr_dist(input logic [PW-1:0] a, input logic [PW-1:0] b);
        logic [PW:0] t;
        t = {1'b0, a} + (PW+1)'(2 * DEPTH) - {1'b0, b};
        if (t >= (PW+1)'(2 * DEPTH)) t = t - (PW+1)'(2 * DEPTH);
        return t[PW-1:0];
    endfunction

    // Per-slot eligibility and store blocking.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic color_hit;
        assign color_hit = (color_q[i] == store_ptr);
        assign elig[i]   = (state_q[i] == LS_WAIT) && (rpl_q[i] || color_hit);
        assign blk[i]    = (state_q[i] == LS_WAIT) && !rpl_q[i] && color_hit;
    end

    // Queue status.
    always_comb begin
        head_idx = ptr_idx(head_q);
        tail_idx = ptr_idx(tail_q);
        full     = (ptr_dist(tail_q, head_q) == PW'(DEPTH));
        st_block = |blk;
    end

    // Oldest eligible slot: scan from the youngest end so the last hit is the oldest.
    always_comb begin
        int j;
        cand     = 1'b0;
        cand_idx = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            j = int'(head_idx) + k;
            if (j >= DEPTH) j = j - DEPTH;
            if (elig[j]) begin
                cand     = 1'b1;
                cand_idx = IW'(j);
            end
        end
    end

    // Slot state transitions and pointer moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                state_q[i] <= LS_FREE;
                color_q[i] <= '0;
            end
            rpl_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc_en) begin
                state_q[tail_idx] <= LS_WAIT;
                color_q[tail_idx] <= alloc_color;
                rpl_q[tail_idx]   <= 1'b0;
                tail_q <= ptr_inc(tail_q);
            end
            if (grant) state_q[cand_idx] <= LS_SENT;
            if (rpl_en && state_q[rpl_idx] == LS_SENT) begin
                state_q[rpl_idx] <= LS_WAIT;
                rpl_q[rpl_idx]   <= 1'b1;
            end
            if (cmp_en && state_q[cmp_idx] == LS_SENT) state_q[cmp_idx] <= LS_DONE;
            if (ret_en && state_q[head_idx] == LS_DONE) begin
                state_q[head_idx] <= LS_FREE;
                head_q <= ptr_inc(head_q);
            end
        end
    end

    // R8: an accepted replay leaves a dispatchable load in the next cycle.
    p_replay_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_en && state_q[rpl_idx] == LS_SENT) |=> cand);
    // R9: retiring an unfinished head does not move the head.
    p_retire_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && state_q[head_idx] != LS_DONE) |=> $stable(head_q));
endmodule

// File: rtl/memord_buf.sv
// Top of the load/store ordering buffer. Routes allocation, completion and
// replay traffic to the two queues and arbitrates the one dispatch slot.
// The next in-order store wins over loads, and loads go out oldest first.
// Assumes: completions and replays name slots that are really in flight.
module memord_buf #(
    parameter int LQ_DEPTH = 16,
    parameter int SQ_DEPTH = 12,
    localparam int LQ_IW = $clog2(LQ_DEPTH),
    localparam int SQ_IW = $clog2(SQ_DEPTH),
    localparam int IW    = (LQ_IW > SQ_IW) ? LQ_IW : SQ_IW,
    localparam int SPW   = $clog2(2 * SQ_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_is_store,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_idx,
    output logic          disp_valid,
    output logic          disp_is_store,
    output logic [IW-1:0] disp_idx,
    input  logic          disp_ready,
    input  logic          cmp_valid,
    input  logic          cmp_is_store,
    input  logic [IW-1:0] cmp_idx,
    input  logic          rpl_valid,
    input  logic [IW-1:0] rpl_idx,
    input  logic          ret_load,
    input  logic          ret_store
);
    logic             sq_full, sq_cand, st_take, st_grant, ld_grant;
    logic [SPW-1:0]   sq_tail_ptr, sq_disp_ptr;
    logic [SQ_IW-1:0] sq_tail_idx, sq_disp_idx;
    logic             lq_full, lq_cand, ld_block;
    logic [LQ_IW-1:0] lq_tail_idx, lq_cand_idx;
    logic             st_alloc, ld_alloc;

    // Allocation routing and back-pressure.
    always_comb begin
        alloc_ready = alloc_is_store ? !sq_full : !lq_full;
        alloc_idx   = alloc_is_store ? IW'(sq_tail_idx) : IW'(lq_tail_idx);
        st_alloc    = alloc_valid && alloc_is_store && !sq_full;
        ld_alloc    = alloc_valid && !alloc_is_store && !lq_full;
    end

    // Dispatch arbitration: the in-order store first, otherwise the oldest load.
    always_comb begin
        st_take       = sq_cand && !ld_block;
        disp_valid    = st_take || lq_cand;
        disp_is_store = st_take;
        disp_idx      = st_take ? IW'(sq_disp_idx) : IW'(lq_cand_idx);
        st_grant      = st_take && disp_ready;
        ld_grant      = !st_take && lq_cand && disp_ready;
    end

    memord_sq #(.DEPTH(SQ_DEPTH)) u_sq (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (st_alloc),
        .full     (sq_full),
        .tail_ptr (sq_tail_ptr),
        .tail_idx (sq_tail_idx),
        .disp_ptr (sq_disp_ptr),
        .disp_idx (sq_disp_idx),
        .cand     (sq_cand),
        .grant    (st_grant),
        .cmp_en   (cmp_valid && cmp_is_store),
        .cmp_idx  (SQ_IW'(cmp_idx)),
        .ret_en   (ret_store)
    );

    memord_lq #(.DEPTH(LQ_DEPTH), .SPW(SPW)) u_lq (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (ld_alloc),
        .alloc_color (sq_tail_ptr),
        .full        (lq_full),
        .tail_idx    (lq_tail_idx),
        .store_ptr   (sq_disp_ptr),
        .st_block    (ld_block),
        .cand        (lq_cand),
        .cand_idx    (lq_cand_idx),
        .grant       (ld_grant),
        .cmp_en      (cmp_valid && !cmp_is_store),
        .cmp_idx     (LQ_IW'(cmp_idx)),
        .rpl_en      (rpl_valid),
        .rpl_idx     (LQ_IW'(rpl_idx)),
        .ret_en      (ret_load)
    );

    // R7: a stalled offer stays unchanged while nothing new arrives.
    p_hold_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && !alloc_valid && !rpl_valid)
        |=> (disp_valid && $stable(disp_is_store) && $stable(disp_idx)));
endmodule

// File: tb/memord_buf_bench.sv
`timescale 1ns/100ps
// Directed bench for the load/store ordering buffer.
module memord_buf_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0, alloc_is_store = 1'b0;
    logic       alloc_ready;
    logic [3:0] alloc_idx;
    logic       disp_valid, disp_is_store;
    logic [3:0] disp_idx;
    logic       disp_ready = 1'b0;
    logic       cmp_valid = 1'b0, cmp_is_store = 1'b0;
    logic [3:0] cmp_idx = '0;
    logic       rpl_valid = 1'b0;
    logic [3:0] rpl_idx = '0;
    logic       ret_load = 1'b0, ret_store = 1'b0;

    int vectors = 0;
    int fails = 0;
    int log_n = 0;
    int log_code [0:63];

    always #2.5 clk = ~clk;

    memord_buf u_memord_buf (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .disp_valid(disp_valid), .disp_is_store(disp_is_store),
        .disp_idx(disp_idx), .disp_ready(disp_ready),
        .cmp_valid(cmp_valid), .cmp_is_store(cmp_is_store), .cmp_idx(cmp_idx),
        .rpl_valid(rpl_valid), .rpl_idx(rpl_idx),
        .ret_load(ret_load), .ret_store(ret_store)
    );

    // Records every accepted dispatch as store*100 + slot.
    always @(negedge clk) begin
        #1;
        if (rst_n && disp_valid && disp_ready && log_n < 64) begin
            log_code[log_n] = (disp_is_store ? 100 : 0) + int'(disp_idx);
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_log(input int k, input int exp, input string req);
        int act;
        act = (k < log_n) ? log_code[k] : -1;
        chk(act == exp, req, act, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        disp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        log_n = 0;
    endtask

    task automatic alloc_op(input bit st, input int exp_idx, input string req);
        alloc_valid = 1'b1;
        alloc_is_store = st;
        #1;
        chk(alloc_ready && int'(alloc_idx) == exp_idx, req, int'(alloc_idx), exp_idx);
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic complete(input bit st, input int idx);
        cmp_valid = 1'b1; cmp_is_store = st; cmp_idx = 4'(idx);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic retire(input bit st);
        ret_load = !st; ret_store = st;
        @(negedge clk);
        ret_load = 1'b0; ret_store = 1'b0;
    endtask

    task automatic replay(input int idx);
        rpl_valid = 1'b1; rpl_idx = 4'(idx);
        @(negedge clk);
        rpl_valid = 1'b0;
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        do_reset();
        #1;
        chk(!disp_valid, "R1 no dispatch", int'(disp_valid), 0);
        alloc_is_store = 1'b1; #0.1;
        chk(alloc_ready, "R1 store queue empty", int'(alloc_ready), 1);
        alloc_is_store = 1'b0; #0.1;
        chk(alloc_ready && alloc_idx == 0, "R1 load queue empty, slot 0", int'(alloc_idx), 0);
        @(negedge clk);
    endtask

    // R3 R4 R5 R7: interleaved loads and stores under back-pressure.
    task automatic t_order();
        do_reset();
        alloc_op(0, 0, "R2 load slot 0");
        alloc_op(0, 1, "R2 load slot 1");
        alloc_op(1, 0, "R2 store slot 0");
        alloc_op(0, 2, "R2 load slot 2");
        alloc_op(1, 1, "R2 store slot 1");
        alloc_op(0, 3, "R2 load slot 3");
        #1;
        chk(disp_valid && !disp_is_store && disp_idx == 0, "R5 oldest load offered",
            int'(disp_idx), 0);
        @(negedge clk);
        #1;
        chk(disp_valid && !disp_is_store && disp_idx == 0, "R7 offer held", int'(disp_idx), 0);
        @(negedge clk);
        disp_ready = 1'b1;
        repeat (8) @(negedge clk);
        chk_log(0, 0,   "R5 first load");
        chk_log(1, 1,   "R5 second load before store");
        chk_log(2, 100, "R3 store after older loads");
        chk_log(3, 2,   "R4 load after older store");
        chk_log(4, 101, "R3 second store");
        chk_log(5, 3,   "R4 last load");
        chk(log_n == 6, "R3 dispatch count", log_n, 6);
    endtask

    // R6 R8: replay of a sent load and store priority.
    task automatic t_replay();
        do_reset();
        disp_ready = 1'b1;
        alloc_op(0, 0, "R2 load slot 0");
        alloc_op(1, 0, "R2 store slot 0");
        @(negedge clk);
        chk_log(0, 0,   "R4 load first");
        chk_log(1, 100, "R3 store next");
        disp_ready = 1'b0;
        log_n = 0;
        replay(0);
        alloc_op(1, 1, "R2 store slot 1");
        #1;
        chk(disp_valid && disp_is_store && disp_idx == 1, "R6 store wins over replayed load",
            int'(disp_is_store) * 100 + int'(disp_idx), 101);
        @(negedge clk);
        disp_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk_log(0, 101, "R6 store dispatched");
        chk_log(1, 0,   "R8 replayed load re-dispatched");
        chk(log_n == 2, "R8 replay count", log_n, 2);
        replay(3);
        #1;
        chk(!disp_valid, "R8 replay of free slot ignored", int'(disp_valid), 0);
        complete(0, 0);
        replay(0);
        #1;
        chk(!disp_valid, "R8 replay of completed load ignored", int'(disp_valid), 0);
        @(negedge clk);
    endtask

    // R5 R2: oldest-first when the load head has wrapped past the top slot.
    task automatic t_wrap_oldest();
        do_reset();
        disp_ready = 1'b1;
        for (int i = 0; i < 15; i++) begin
            alloc_op(0, i, "R2 cycling load slot");
            @(negedge clk);
            complete(0, i);
            retire(0);
        end
        disp_ready = 1'b0;
        log_n = 0;
        alloc_op(0, 15, "R2 top slot");
        alloc_op(0, 0, "R2 slot wraps to 0");
        #1;
        chk(disp_valid && !disp_is_store && disp_idx == 15, "R5 oldest across wrap",
            int'(disp_idx), 15);
        @(negedge clk);
        disp_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk_log(0, 15, "R5 wrap order first");
        chk_log(1, 0,  "R5 wrap order second");
    endtask

    // R2 R9: full load queue and in-order retirement.
    task automatic t_load_full();
        do_reset();
        for (int i = 0; i < 16; i++) alloc_op(0, i, "R2 fill load queue");
        alloc_valid = 1'b1; alloc_is_store = 1'b0; #1;
        chk(!alloc_ready, "R2 load queue full", int'(alloc_ready), 0);
        alloc_is_store = 1'b1; #0.1;
        chk(alloc_ready, "R2 store queue unaffected", int'(alloc_ready), 1);
        alloc_is_store = 1'b0;
        @(negedge clk);
        alloc_valid = 1'b0;
        disp_ready = 1'b1;
        repeat (17) @(negedge clk);
        chk(log_n == 16, "R5 all loads dispatched", log_n, 16);
        chk_log(0, 0,   "R5 load order first");
        chk_log(15, 15, "R5 load order last");
        complete(0, 1);
        retire(0);
        #1;
        chk(!alloc_ready, "R9 unfinished head not retired", int'(alloc_ready), 0);
        @(negedge clk);
        complete(0, 0);
        retire(0);
        #1;
        chk(alloc_ready && alloc_idx == 0, "R9 finished head retired", int'(alloc_idx), 0);
        @(negedge clk);
    endtask

    // R2 R3 R10: full store queue, drain, and ordering after the tag wrap.
    task automatic t_store_wrap();
        do_reset();
        for (int i = 0; i < 12; i++) alloc_op(1, i, "R2 fill store queue");
        alloc_valid = 1'b1; alloc_is_store = 1'b1; #1;
        chk(!alloc_ready, "R2 store queue full", int'(alloc_ready), 0);
        alloc_is_store = 1'b0; #0.1;
        chk(alloc_ready, "R2 load queue unaffected", int'(alloc_ready), 1);
        alloc_is_store = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0;
        disp_ready = 1'b1;
        repeat (13) @(negedge clk);
        chk(log_n == 12, "R3 stores dispatched once each", log_n, 12);
        chk_log(0, 100,  "R3 store order first");
        chk_log(11, 111, "R3 store order last");
        for (int i = 0; i < 12; i++) complete(1, i);
        for (int i = 0; i < 12; i++) retire(1);
        alloc_is_store = 1'b1; #1;
        chk(alloc_ready && alloc_idx == 0, "R10 drained queue reads empty",
            int'(alloc_ready), 1);
        @(negedge clk);
        disp_ready = 1'b0;
        log_n = 0;
        alloc_op(0, 0, "R2 load after wrap");
        alloc_op(1, 0, "R2 store after wrap");
        #1;
        chk(disp_valid && !disp_is_store, "R10 older load eligible after wrap",
            int'(disp_is_store), 0);
        @(negedge clk);
        disp_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk_log(0, 0,   "R10 load before store");
        chk_log(1, 100, "R10 store after load");
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_order();
        t_replay();
        t_wrap_oldest();
        t_load_full();
        t_store_wrap();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule